// File: doc/BRIEF.md
# Synchronous Serial Character Receiver

This block receives serial characters on one data line, `rxd`. An external bit-rate clock, `sclk`, supplies the timing, and the block takes exactly one sample of the line per bit, on each rising edge of that clock. It does not oversample, align to mid-bit or vote between samples. While the receiver is idle, a single low sample is enough to start a character.

After the start bit the block shifts in the data bits, least significant bit first. It then captures a parity bit if parity is enabled, and then one or two stop bits. The finished character is placed in an output register together with three flags: parity error, framing error and overrun. The register is read through a valid/ready handshake.

Three configuration inputs set the character: its length, its parity mode and its stop-bit count. The block samples them when it sees the start bit. `sclk` must be generated in the same clock domain as `clk`. The block finds the rising edge of `sclk` by comparing it with a registered copy of itself. An enable input stops reception and discards any character that is partly received.

Top module: `sync_char_rx`

## Requirements
- R1: A line sample is taken on each `clk` edge at which `sclk` is high and was low on the previous `clk` edge. While the receiver is idle and `en` is high, a low sample starts a character and a high sample is ignored.
- R2: The number of data bits is 5 + `cfg_len` (codes 0..4 give 5..9 bits; codes 5..7 give 9). The first data sample goes to `rx_data[0]`. Bits of `rx_data` above the character length read 0.
- R3: The data bits are followed by one parity sample when `cfg_par` < 4. Then come one stop sample when `cfg_stop2` = 0, or two when it is 1. The receiver then goes idle, and the very next low sample starts a new character.
- R4: The parity modes are selected by `cfg_par`: 0 even, 1 odd, 2 parity bit forced to 0, 3 parity bit forced to 1, 4..7 no parity. `rx_perr` is 1 when the received parity bit differs from the bit the selected mode expects. It is always 0 with no parity.
- R5: `rx_ferr` is 1 when any stop sample is low. The character is delivered either way.
- R6: The output register loads on the `clk` edge after the edge that sampled the last stop bit, and `rx_valid` rises. It holds its contents until a `clk` edge at which `rx_ready` is high, and that edge clears `rx_valid`.
- R7: If a character loads while `rx_valid` is high and `rx_ready` is low, it replaces the old one and `rx_ovr` = 1. Otherwise a load sets `rx_ovr` = 0.
- R8: While `en` is low, the receiver returns to idle, a partly received character is dropped, and line samples are ignored.
- R9: After reset, `rx_valid`, `rx_data`, `rx_perr`, `rx_ferr` and `rx_ovr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Receiver enable; low forces idle |
| sclk | input | 1 | Bit-rate clock, synchronous to clk |
| rxd | input | 1 | Serial data line |
| cfg_len | input | 3 | Data length code (5 + code, capped at MAX_BITS) |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| rx_ready | input | 1 | Consumer accepts the held character |
| rx_valid | output | 1 | Output register holds a character |
| rx_data | output | MAX_BITS | Received character, LSB-aligned |
| rx_perr | output | 1 | Parity error flag of the held character |
| rx_ferr | output | 1 | Framing error flag of the held character |
| rx_ovr | output | 1 | Held character overwrote an unread one |

## Verification
The bench covers every length from 5 to 9 bits. A receiver that miscounts the length would shift parity or stop samples into the data, or take data samples as stop bits, and the character would come out shifted or misflagged. Each parity mode is sent with a correct parity bit and with a wrong one, so an inverted parity sense or a forced mode that ignores the line shows up in `rx_perr`. A bad first stop bit is sent with two stop bits selected; a receiver that checks only the last stop sample would miss that error.

Two characters are sent back to back without a read in between. A receiver that needs an idle sample before a new start would lose the second character, and one that keeps the first character would never report overrun. A character is cut off by dropping `en` while low bits keep arriving. A receiver that kept its count, or took those low bits as a start, would deliver garbage or realign the next character wrongly.

// File: rtl/sync_rx_pkg.sv
// Package sync_rx_pkg
// Shared state encoding and parity helpers for the synchronous character
// receiver. Assumes parity mode codes: 0 even, 1 odd, 2 zero, 3 one, >=4 none.
package sync_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DATA  = 3'd1,
        ST_PAR   = 3'd2,
        ST_STOP1 = 3'd3,
        ST_STOP2 = 3'd4
    } rx_state_e;

    // True when the mode code carries a parity bit on the line.
    function automatic logic parity_on(input logic [2:0] mode);
        return (mode[2] == 1'b0);
    endfunction

    // Parity bit the mode expects, given the XOR of the data bits.
    function automatic logic parity_expect(input logic [2:0] mode, input logic data_xor);
        logic r;
        case (mode[1:0])
            2'd0:    r = data_xor;
            2'd1:    r = ~data_xor;
            2'd2:    r = 1'b0;
            default: r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sync_rx_edge.sv
// Module sync_rx_edge
// Produces a one-cycle tick on each rising edge of the bit-rate clock.
// Assumes sclk is generated in the clk domain (no synchroniser needed) and
// stays high and low for at least one clk cycle each.
module sync_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic tick
);

    logic sclk_q;

    // Remember the bit clock level of the previous system clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign tick = sclk & ~sclk_q;

    // R1: a tick never repeats on consecutive cycles.
    a_r1_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sync_rx_frame.sv
// Module sync_rx_frame
// Character framing state machine: start detection, LSB-first data capture,
// optional parity and one or two stop samples. Emits a one-cycle done pulse
// with flags; the data vector stays stable until the next start bit.
// Assumes tick is a single-cycle strobe; configuration is latched at start.
module sync_rx_frame
    import sync_rx_pkg::*;
#(
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                tick,
    input  logic                rxd,
    input  logic [2:0]          cfg_len,
    input  logic [2:0]          cfg_par,
    input  logic                cfg_stop2,
    output logic                done_o,
    output logic [MAX_BITS-1:0] data_o,
    output logic                perr_o,
    output logic                ferr_o
);

    localparam int         CNT_W  = $clog2(MAX_BITS);
    localparam logic [3:0] MAX_L  = 4'(MAX_BITS);

    rx_state_e           state;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    last_idx;
    logic [CNT_W-1:0]    last_next;
    logic [2:0]          par_mode;
    logic                two_stop;
    logic                par_bit;
    logic                ferr_acc;
    logic [MAX_BITS-1:0] shreg;
    logic [3:0]          len_sum;
    logic [3:0]          len_clamp;
    logic                start;
    logic                data_tick;
    logic                perr_calc;

    // Decode the configured character length into the last data index.
    assign len_sum   = 4'd5 + {1'b0, cfg_len};
    assign len_clamp = (len_sum > MAX_L) ? MAX_L : len_sum;
    assign last_next = CNT_W'(len_clamp - 4'd1);

    assign start     = en && tick && (state == ST_IDLE) && !rxd;
    assign data_tick = en && tick && (state == ST_DATA);
    assign perr_calc = parity_on(par_mode) && (par_bit != parity_expect(par_mode, ^shreg));

    // Frame sequencing and flag capture, one step per sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            last_idx <= '0;
            par_mode <= 3'd4;
            two_stop <= 1'b0;
            par_bit  <= 1'b0;
            ferr_acc <= 1'b0;
            done_o   <= 1'b0;
            perr_o   <= 1'b0;
            ferr_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
            end else if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rxd) begin
                            state    <= ST_DATA;
                            cnt      <= '0;
                            last_idx <= last_next;
                            par_mode <= cfg_par;
                            two_stop <= cfg_stop2;
                            ferr_acc <= 1'b0;
                        end
                    end
                    ST_DATA: begin
                        cnt <= cnt + CNT_W'(1);
                        if (cnt == last_idx)
                            state <= parity_on(par_mode) ? ST_PAR : ST_STOP1;
                    end
                    ST_PAR: begin
                        par_bit <= rxd;
                        state   <= ST_STOP1;
                    end
                    ST_STOP1: begin
                        if (two_stop) begin
                            ferr_acc <= !rxd;
                            state    <= ST_STOP2;
                        end else begin
                            state  <= ST_IDLE;
                            done_o <= 1'b1;
                            ferr_o <= !rxd;
                            perr_o <= perr_calc;
                        end
                    end
                    ST_STOP2: begin
                        state  <= ST_IDLE;
                        done_o <= 1'b1;
                        ferr_o <= ferr_acc | !rxd;
                        perr_o <= perr_calc;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // One capture flop per data bit, cleared at start, written at its index.
    for (genvar i = 0; i < MAX_BITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                                shreg[i] <= 1'b0;
            else if (start)                            shreg[i] <= 1'b0;
            else if (data_tick && cnt == CNT_W'(i))    shreg[i] <= rxd;
        end
    end

    assign data_o = shreg;

    // R8: disabling forces idle and suppresses completion.
    a_r8_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE && !done_o));

    // R1: a high sample while idle does not start a character.
    a_r1_high_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_IDLE && (!tick || rxd)) |=> (state == ST_IDLE));

    // R3: the final stop sample completes the character and returns to idle.
    a_r3_stop_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && (state == ST_STOP2 || (state == ST_STOP1 && !two_stop)))
        |=> (state == ST_IDLE && done_o));

    // R6: completion is a single-cycle pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/sync_rx_hold.sv
// Module sync_rx_hold
// Output register with valid/ready handshake and overrun marking.
// Assumes load is a single-cycle strobe with data/flags stable in that cycle.
module sync_rx_hold #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d_in,
    input  logic         perr_in,
    input  logic         ferr_in,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] d_out,
    output logic         perr_out,
    output logic         ferr_out,
    output logic         ovr_out
);

    // Load a finished character or release the held one on a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            d_out    <= '0;
            perr_out <= 1'b0;
            ferr_out <= 1'b0;
            ovr_out  <= 1'b0;
        end else if (load) begin
            valid    <= 1'b1;
            d_out    <= d_in;
            perr_out <= perr_in;
            ferr_out <= ferr_in;
            ovr_out  <= valid && !ready;
        end else if (valid && ready) begin
            valid <= 1'b0;
        end
    end

    // R6: a load always presents a character.
    a_r6_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> valid);

    // R6: an unread character is held unchanged.
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && !load) |=> (valid && $stable(d_out)));

    // R6: a handshake without a new load empties the register.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !load) |=> !valid);

    // R7: loading over an unread character marks overrun.
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (load && valid && !ready) |=> ovr_out);

endmodule

// File: rtl/sync_char_rx.sv
// Module sync_char_rx
// Top of the synchronous serial character receiver: bit-clock edge detect,
// framing state machine and handshaked output register.
// Assumes sclk is in the clk domain and 5 <= MAX_BITS <= 12.
module sync_char_rx #(
    parameter int MAX_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                sclk,
    input  logic                rxd,
    input  logic [2:0]          cfg_len,
    input  logic [2:0]          cfg_par,
    input  logic                cfg_stop2,
    input  logic                rx_ready,
    output logic                rx_valid,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_perr,
    output logic                rx_ferr,
    output logic                rx_ovr
);

    logic                tick;
    logic                done;
    logic [MAX_BITS-1:0] chr;
    logic                perr;
    logic                ferr;

    sync_rx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk  (sclk),
        .tick  (tick)
    );

    sync_rx_frame #(.MAX_BITS(MAX_BITS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .rxd       (rxd),
        .cfg_len   (cfg_len),
        .cfg_par   (cfg_par),
        .cfg_stop2 (cfg_stop2),
        .done_o    (done),
        .data_o    (chr),
        .perr_o    (perr),
        .ferr_o    (ferr)
    );

    sync_rx_hold #(.W(MAX_BITS)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (done),
        .d_in     (chr),
        .perr_in  (perr),
        .ferr_in  (ferr),
        .ready    (rx_ready),
        .valid    (rx_valid),
        .d_out    (rx_data),
        .perr_out (rx_perr),
        .ferr_out (rx_ferr),
        .ovr_out  (rx_ovr)
    );

endmodule

// File: tb/sync_char_rx_test.sv
module sync_char_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic       clk = 1'b0;
    logic       rst_n, en, sclk, rxd, rx_ready;
    logic [2:0] cfg_len, cfg_par;
    logic       cfg_stop2;
    logic       rx_valid, rx_perr, rx_ferr, rx_ovr;
    logic [8:0] rx_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_char_rx uut (
        .clk(clk), .rst_n(rst_n), .en(en), .sclk(sclk), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
    );

    // ---------------- behavioural reference model ----------------
    bit       m_valid, m_perr, m_ferr, m_ovr, m_pend, m_busy, m_prev;
    int       m_data, p_data;
    bit       p_perr, p_ferr;
    int       m_n, m_par, m_stops, m_need;
    bit       m_bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 0; m_perr = 0; m_ferr = 0; m_ovr = 0; m_data = 0;
            m_pend = 0; m_busy = 0; m_prev = 0;
            m_bits.delete();
        end else begin
            if (m_pend) begin
                m_ovr = m_valid && !rx_ready;
                m_valid = 1; m_data = p_data; m_perr = p_perr; m_ferr = p_ferr;
                m_pend = 0;
            end else if (m_valid && rx_ready) begin
                m_valid = 0;
            end
            if (!en) begin
                m_busy = 0;
            end else if (sclk && !m_prev) begin
                if (!m_busy) begin
                    if (!rxd) begin
                        m_busy = 1;
                        m_bits.delete();
                        m_n = (5 + int'(cfg_len) > 9) ? 9 : 5 + int'(cfg_len);
                        m_par = int'(cfg_par);
                        m_stops = cfg_stop2 ? 2 : 1;
                        m_need = m_n + ((m_par < 4) ? 1 : 0) + m_stops;
                    end
                end else begin
                    m_bits.push_back(rxd);
                    if (m_bits.size() == m_need) begin
                        int ones, idx;
                        bit pb, pexp;
                        p_data = 0; ones = 0;
                        for (int i = 0; i < m_n; i++) begin
                            if (m_bits[i]) begin p_data += (1 << i); ones++; end
                        end
                        idx = m_n;
                        p_perr = 0;
                        if (m_par < 4) begin
                            pb = m_bits[idx]; idx++;
                            case (m_par)
                                0: pexp = (ones % 2) == 1;
                                1: pexp = (ones % 2) == 0;
                                2: pexp = 0;
                                default: pexp = 1;
                            endcase
                            p_perr = (pb != pexp);
                        end
                        p_ferr = 0;
                        for (int i = idx; i < m_need; i++) if (!m_bits[i]) p_ferr = 1;
                        m_pend = 1;
                        m_busy = 0;
                    end
                end
            end
            m_prev = sclk;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(rx_valid == m_valid, "R6 model valid", rx_valid, m_valid);
            if (m_valid) begin
                chk(int'(rx_data) == m_data, "R2 model data", rx_data, m_data);
                chk(rx_perr == m_perr, "R4 model perr", rx_perr, m_perr);
                chk(rx_ferr == m_ferr, "R5 model ferr", rx_ferr, m_ferr);
                chk(rx_ovr == m_ovr, "R7 model ovr", rx_ovr, m_ovr);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_bit(input bit b);
        @(negedge clk); rxd = b; sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (1) @(negedge clk);
    endtask

    task automatic send_frame(input int n, input int par, input bit two,
                              input int d, input bit bad_par, input bit bad_stop);
        int ones;
        bit pb;
        @(negedge clk);
        cfg_len = 3'(n - 5); cfg_par = 3'(par); cfg_stop2 = two;
        send_bit(1'b0);
        ones = 0;
        for (int i = 0; i < n; i++) begin
            send_bit(d[i]);
            if (d[i]) ones++;
        end
        if (par < 4) begin
            case (par)
                0: pb = (ones % 2) == 1;
                1: pb = (ones % 2) == 0;
                2: pb = 0;
                default: pb = 1;
            endcase
            send_bit(pb ^ bad_par);
        end
        send_bit(!bad_stop);
        if (two) send_bit(1'b1);
        rxd = 1'b1;
    endtask

    task automatic expect_char(input int d, input int n, input bit pe, input bit fe,
                               input bit ov);
        int mask;
        mask = (1 << n) - 1;
        repeat (2) @(negedge clk);
        chk(rx_valid == 1'b1, "R6 char presented", rx_valid, 1);
        chk(int'(rx_data) == (d & mask), "R2 data LSB first", rx_data, d & mask);
        chk(rx_perr == pe, "R4 parity flag", rx_perr, pe);
        chk(rx_ferr == fe, "R5 framing flag", rx_ferr, fe);
        chk(rx_ovr == ov, "R7 overrun flag", rx_ovr, ov);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk(rx_valid == 1'b0, "R6 released by ready", rx_valid, 0);
    endtask

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        rst_n = 0; en = 0; sclk = 0; rxd = 1; rx_ready = 0;
        cfg_len = 3'd3; cfg_par = 3'd0; cfg_stop2 = 0;
        repeat (4) @(negedge clk);
        // R9: reset state
        chk(rx_valid == 0, "R9 reset valid", rx_valid, 0);
        chk(rx_data == 0, "R9 reset data", rx_data, 0);
        chk({rx_perr, rx_ferr, rx_ovr} == 3'b000, "R9 reset flags",
            {rx_perr, rx_ferr, rx_ovr}, 0);
        rst_n = 1; en = 1;

        // R1: high samples while idle start nothing
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        repeat (3) @(negedge clk);
        chk(rx_valid == 0, "R1 idle highs ignored", rx_valid, 0);

        // reference case: 8 bits, even parity, 1 stop
        send_frame(8, 0, 0, 'hA5, 0, 0);
        expect_char('hA5, 8, 0, 0, 0);

        // R2 / R3: every length, no parity, two stops
        for (int n = 5; n <= 9; n++) begin
            send_frame(n, 4, 1, 'h16B + n, 0, 0);
            expect_char('h16B + n, n, 0, 0, 0);
        end

        // R4: each parity mode good and bad
        for (int p = 0; p < 4; p++) begin
            send_frame(7, p, 0, 'h53, 0, 0);
            expect_char('h53, 7, 0, 0, 0);
            send_frame(7, p, 0, 'h2C, 1, 0);
            expect_char('h2C, 7, 1, 0, 0);
        end

        // R5: bad first stop with two stops, character still delivered
        send_frame(8, 1, 1, 'h3C, 0, 1);
        expect_char('h3C, 8, 0, 1, 0);
        send_frame(6, 4, 0, 'h15, 0, 1);
        expect_char('h15, 6, 0, 1, 0);

        // R3 / R7: back-to-back characters without a read
        send_frame(8, 4, 0, 'h11, 0, 0);
        send_frame(8, 4, 0, 'hEE, 0, 0);
        expect_char('hEE, 8, 0, 0, 1);

        // R8: abort mid-character, ticks with en low ignored
        send_frame(5, 4, 0, 0, 0, 0);   // drained character of zeros
        expect_char(0, 5, 0, 0, 0);
        @(negedge clk); cfg_len = 3'd3; cfg_par = 3'd4; cfg_stop2 = 0;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        en = 0;
        for (int i = 0; i < 12; i++) send_bit(1'b0);
        repeat (3) @(negedge clk);
        chk(rx_valid == 0, "R8 disabled no delivery", rx_valid, 0);
        en = 1;
        send_bit(1'b1);
        send_frame(8, 4, 0, 'h96, 0, 0);
        expect_char('h96, 8, 0, 0, 0);

        // R7: a read between characters clears the overrun mark
        send_frame(9, 0, 1, 'h1F0, 0, 0);
        expect_char('h1F0, 9, 0, 0, 0);

        repeat (4) @(negedge clk);
        summary();
    end

endmodule